// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst in front of a pipelined synchronous memory. In a load cycle it registers a new external address. In each advance cycle after that it moves on to the next beat. Only the two lowest address bits change during a burst. The upper bits keep the value they had in the load cycle until the next load.

A static order input selects one of two beat orders. Linear order steps the low bits by one and wraps modulo four. Interleaved order outputs the loaded low bits XOR a beat count that runs 0, 1, 2, 3. When advances continue past the fourth beat, the same four addresses repeat.

A clock enable freezes the whole block. While it is low, the address and the beat count both hold, whatever the other inputs do.

Top module: `seq_burst_addr`

## Requirements
- R1: While `rst_n` is low, and after reset before any enabled cycle, `addr_out` is zero.
- R2: After a rising edge with `clk_en`=1 and `ld_nadv`=1 (1 means load), `addr_out` equals the `addr_in` value sampled at that edge.
- R3: With `order_ilv`=0 (linear), each enabled cycle with `ld_nadv`=0 (advance) sets the low two bits of `addr_out` to their previous value plus one, modulo 4. For example, start 1 gives 1, 2, 3, 0.
- R4: With `order_ilv`=1 (interleaved), after n advances since the load the low two bits of `addr_out` equal the loaded low bits XOR (n mod 4). For example, start 1 gives 1, 0, 3, 2.
- R5: During advance cycles, bits above bit 1 of `addr_out` keep their loaded value, and `addr_in` has no effect.
- R6: Four advances after a load bring `addr_out` back to the loaded address. Further advances repeat the same sequence.
- R7: A rising edge with `clk_en`=0 changes neither `addr_out` nor the beat position, whatever `ld_nadv` and `addr_in` are.
- R8: A load in the middle of a burst restarts the sequence at beat 0 from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | 1 lets the cycle take effect; 0 freezes the block |
| ld_nadv | input | 1 | 1 loads `addr_in`; 0 advances the burst |
| order_ilv | input | 1 | 0 selects linear order; 1 selects interleaved order |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Address of the current beat |

## Verification
The bench builds the block with `ADDR_W`=8. At that width the upper six bits can be checked in full. The advance rows drive an all-ones `addr_in`, so any leak of the external address into the upper bits shows up on the output. Start values 1 and 3 are used in interleaved order, because there the XOR sequence differs most from the linear one. A start value of 0 is also run, where the two orders give the same sequence. One frozen cycle is placed inside an interleaved burst, which checks that the beat count resumes where it stopped.

// File: rtl/seq_pkg.sv
package seq_pkg;
    // Number of low address bits stepped by a burst (four beats)
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/seq_beat_counter.sv
module seq_beat_counter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] nxt_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        nxt_o = clr ? '0 : W'(ctr_q.cnt + 1'b1);
        if (en) begin
            ctr_d.cnt = nxt_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt_o = ctr_q.cnt;

    // R6: the beat count wraps modulo 2**W when it advances
    p_count_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (cnt_o == W'($past(cnt_o) + 1'b1)));

    // R8: a load restarts the count at beat 0
    p_count_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr) |=> (cnt_o == '0));

    // R7: the count holds while disabled
    p_count_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_o));
endmodule

// File: rtl/seq_order_unit.sv
module seq_order_unit #(
    parameter int W = 2
) (
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] beat_i,
    input  logic         ilv_i,
    output logic [W-1:0] low_o
);
    logic [W-1:0] lin_w;
    logic [W-1:0] ilv_w;

    // Linear order: offset from the start, wrapping at 2**W
    assign lin_w = W'(start_i + beat_i);

    // Interleaved order: each bit of the start flipped by the beat index
    for (genvar gi = 0; gi < W; gi++) begin : g_xor
        assign ilv_w[gi] = start_i[gi] ^ beat_i[gi];
    end

    assign low_o = ilv_i ? ilv_w : lin_w;
endmodule

// File: rtl/seq_burst_addr.sv
module seq_burst_addr #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              ld_nadv,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    import seq_pkg::*;

    localparam int BW = BEAT_W;
    localparam int UW = ADDR_W - BW;

    typedef struct packed {
        logic [UW-1:0] upper;
        logic [BW-1:0] start;
        logic [BW-1:0] low;
    } st_t;

    st_t st_d, st_q;

    logic [BW-1:0] cnt_q;
    logic [BW-1:0] cnt_nxt;
    logic [BW-1:0] start_sel;
    logic [BW-1:0] low_nxt;
    order_e        ord;

    assign ord       = order_e'(order_ilv);
    assign start_sel = ld_nadv ? addr_in[BW-1:0] : st_q.start;

    seq_beat_counter #(.W(BW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .clr   (ld_nadv),
        .cnt_o (cnt_q),
        .nxt_o (cnt_nxt)
    );

    seq_order_unit #(.W(BW)) u_ord (
        .start_i (start_sel),
        .beat_i  (cnt_nxt),
        .ilv_i   (ord == ORD_INTERLEAVE),
        .low_o   (low_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (ld_nadv) begin
                st_d.upper = addr_in[ADDR_W-1:BW];
                st_d.start = addr_in[BW-1:0];
            end
            st_d.low = low_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_out = {st_q.upper, st_q.low};

    // R2: a load presents the external address on the next cycle
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && ld_nadv) |=> (addr_out == $past(addr_in)));

    // R3: linear advance steps the low bits by one
    p_linear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !ld_nadv && !order_ilv) |=>
        (addr_out[BW-1:0] == BW'($past(addr_out[BW-1:0]) + 1'b1)));

    // R4: interleaved low bits are the start XOR the beat count
    p_interleave_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !ld_nadv && order_ilv) |=>
        ((addr_out[BW-1:0] ^ st_q.start) == cnt_q));

    // R5: upper bits do not move during advances
    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !ld_nadv) |=> $stable(addr_out[ADDR_W-1:BW]));

    // R7: a disabled cycle freezes the output
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(addr_out));
endmodule

// File: tb/sim_seq_burst_addr.sv
module sim_seq_burst_addr;
    localparam int AW = 8;
    localparam int NV = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          ld_nadv = 1'b0;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seq_burst_addr #(.ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .ld_nadv   (ld_nadv),
        .order_ilv (order_ilv),
        .addr_in   (addr_in),
        .addr_out  (addr_out)
    );

    // {req[3:0], en, ld, ilv, addr_in[7:0], expected[7:0]}
    localparam logic [22:0] VEC [NV] = '{
        {4'd2, 1'b1, 1'b1, 1'b0, 8'hA5, 8'hA5}, // R2 load, linear, start 1
        {4'd3, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA6}, // R3 / R5
        {4'd3, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA7}, // R3
        {4'd3, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA4}, // R3 wraps low bits
        {4'd6, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA5}, // R6 back to start
        {4'd7, 1'b0, 1'b1, 1'b0, 8'h33, 8'hA5}, // R7 load ignored
        {4'd7, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hA5}, // R7 advance ignored
        {4'd2, 1'b1, 1'b1, 1'b1, 8'h3D, 8'h3D}, // R2 load, interleaved, start 1
        {4'd4, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h3C}, // R4 1^1
        {4'd4, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h3F}, // R4 1^2
        {4'd4, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h3E}, // R4 1^3
        {4'd6, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h3D}, // R6 wrap
        {4'd6, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h3C}, // R6 repeats
        {4'd8, 1'b1, 1'b1, 1'b0, 8'h52, 8'h52}, // R8 load mid-burst
        {4'd8, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h53}, // R8 restarts at beat 0
        {4'd2, 1'b1, 1'b1, 1'b1, 8'hC3, 8'hC3}, // R2 interleaved, start 3
        {4'd4, 1'b1, 1'b0, 1'b1, 8'hFF, 8'hC2}, // R4 3^1
        {4'd7, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hC2}, // R7 frozen mid-burst
        {4'd4, 1'b1, 1'b0, 1'b1, 8'hFF, 8'hC1}, // R4 3^2 after freeze
        {4'd4, 1'b1, 1'b0, 1'b1, 8'hFF, 8'hC0}, // R4 3^3
        {4'd5, 1'b1, 1'b0, 1'b1, 8'h00, 8'hC3}  // R5 upper held, R6 wrap
    };

    task automatic check(input string req, input logic [AW-1:0] exp);
        n_run++;
        if (addr_out !== exp) begin
            n_fail++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    // One cycle: drive after the falling edge, sample at the next falling edge
    task automatic step(input logic en, input logic ld, input logic ilv,
                        input logic [AW-1:0] a);
        clk_en    = en;
        ld_nadv   = ld;
        order_ilv = ilv;
        addr_in   = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:8]);
            check($sformatf("R%0d row %0d", VEC[i][22:19], i), VEC[i][7:0]);
        end

        // R1: reset in the middle of a burst
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 8'h00);
        rst_n = 1'b1;

        // R3 / R4: start 0 gives the same sequence in both orders
        step(1'b1, 1'b1, 1'b1, 8'h80);
        check("R2", 8'h80);
        step(1'b1, 1'b0, 1'b1, 8'h7F);
        check("R4", 8'h81);
        step(1'b1, 1'b0, 1'b1, 8'h7F);
        check("R4", 8'h82);
        step(1'b1, 1'b0, 1'b1, 8'h7F);
        check("R4", 8'h83);
        step(1'b1, 1'b1, 1'b0, 8'h18);
        check("R8", 8'h18);
        step(1'b1, 1'b0, 1'b0, 8'h7F);
        check("R3", 8'h19);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule